// File: doc/BRIEF.md
# Parallel Multicolumn Read Cache with Speculative Word Dispatch

This block is a read-only, n-way associative cache. The tags sit in one bank per column, and all of them are compared in the same cycle. The data words sit in one single memory that is read one word per cycle. Column 0 of each set is the major location and always holds the most recently referenced block of that set. On every accepted request the cache reads the major word and sends it to the consumer in the same cycle that the tag compare runs. The consumer learns from a confirm or a cancel flag whether that word is good. Because the tag compare only tells the consumer to keep or discard a word, no data multiplexer sits behind it.

When the requested block is in another column, the consumer gets the correct word one cycle later. The matching column number forms the data address for that second read. After this second-column hit, the block is exchanged with the major one. When no column matches, the old major block moves to a victim column. The cache then requests the block from the lower level over a valid/ready handshake and forwards the requested word in the cycle it arrives. New requests are held off while a swap or a fill is in progress.

Top module: `pmc_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. All entries start invalid, so the first reference to any block is a miss.
- R2: The request address is split as offset = `addr[1:0]`, set = `addr[4:2]` and tag = `addr[15:5]` (defaults). One cycle after a request is accepted, `rsp_valid` is 1 and `rsp_data` is the word held in column 0 at that set and offset, whatever the outcome.
- R3: When the column-0 tag matches (first hit), `rsp_confirm` is 1 in the dispatch cycle and `req_ready` stays 1, so the next request can be accepted in that same cycle.
- R4: `rsp_confirm` and `rsp_cancel` are never high together, and neither is high without `rsp_valid`. `rsp_cancel` is high in the dispatch cycle whenever the column-0 tag does not match.
- R5: When another column matches (second hit), the cycle after the cancel carries the correct word with `rsp_confirm`, and no lower-level request is made.
- R6: On a miss, `mem_req_valid` rises with block address {tag, set} and holds, with that address stable, until `mem_req_ready`. The lower level then returns the block's words in offset order, one on each `mem_rsp_valid`, with idle cycles allowed between them. The requested word goes out with `rsp_confirm` in the same cycle its fill word is presented.
- R7: After a second hit, the referenced block and the old major block exchange columns. A repeated reference to the first block is a first hit, and a reference to the displaced block is a second hit.
- R8: On a miss, the old major block moves to the lowest-numbered invalid non-major column. When all non-major columns are valid, it moves to the column given by a per-set rotating pointer. That pointer starts at 1, steps 1, 2, …, n−1 cyclically, and moves only when it is used. The new block goes into column 0.
- R9: From the cycle after a dispatch that is not a first hit until the swap or fill completes, `req_ready` is 0. Each request yields exactly one confirmed word, and no response appears outside the cycles stated above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | A word is presented on rsp_data |
| rsp_data | output | DATA_W | Presented word |
| rsp_confirm | output | 1 | Presented word is the requested one |
| rsp_cancel | output | 1 | Presented word is speculative and must be dropped |
| mem_req_valid | output | 1 | Block fetch request to the lower level |
| mem_req_addr | output | ADDR_W-log2(WORDS) | Block address {tag, set} |
| mem_req_ready | input | 1 | Lower level takes the fetch request |
| mem_rsp_valid | input | 1 | Fill word present |
| mem_rsp_data | input | DATA_W | Fill word, in offset order |

## Verification
Two functions can fall in the same cycle here. The first is confirming one request's speculative word. The second is accepting the next request, which launches that request's major-location read. Directed and pseudo-random streams provoke this by issuing a new request in the very cycle a first hit is dispatched. The bench then judges the follow-on word one cycle later against the contents its behavioural model expects in column 0. A second overlap is a fill word being written into the major location in the cycle it is forwarded to the consumer. The bench checks this with fills that have idle gaps and a delayed request acceptance.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RETRY,
        ST_LOAD,
        ST_COPY,
        ST_STORE,
        ST_FILL_REQ,
        ST_FILL
    } pmc_state_t;

    typedef enum logic [1:0] {
        TU_NONE,
        TU_EXCHANGE,
        TU_INSTALL
    } tag_op_t;

    // rotating replacement pointer over the non-major columns 1..ways-1
    function automatic int unsigned rot_next(input int unsigned cur, input int unsigned ways);
        return (cur >= ways - 1) ? 1 : cur + 1;
    endfunction

endpackage

// File: rtl/pmc_data_bank.sv
module pmc_data_bank #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        rd_data <= mem_q[rd_addr];
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/pmc_tag_banks.sv
module pmc_tag_banks
    import pmc_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 11,
    localparam int SET_W = $clog2(SETS),
    localparam int CW    = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic [CW-1:0]    victim,
    input  tag_op_t          op,
    input  logic [CW-1:0]    op_col
);

    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_vld;
    logic [WAYS-1:0][TAG_W-1:0] wr_tag;
    logic [WAYS-1:0]            wr_vld;
    logic [WAYS-1:0]            wr_en;

    for (genvar c = 0; c < WAYS; c++) begin : g_bank
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;

        assign rd_tag[c]  = tag_q[lk_set];
        assign rd_vld[c]  = vld_q[lk_set];
        assign hit_vec[c] = rd_vld[c] && (rd_tag[c] == lk_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (wr_en[c]) begin
                vld_q[lk_set] <= wr_vld[c];
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en[c]) begin
                tag_q[lk_set] <= wr_tag[c];
            end
        end
    end

    // write decode for the two tag operations
    always_comb begin
        wr_en  = '0;
        wr_tag = rd_tag;
        wr_vld = rd_vld;
        case (op)
            TU_EXCHANGE: begin
                wr_en[0]       = 1'b1;
                wr_en[op_col]  = 1'b1;
                wr_tag[op_col] = rd_tag[0];
                wr_vld[op_col] = rd_vld[0];
                wr_tag[0]      = rd_tag[op_col];
                wr_vld[0]      = rd_vld[op_col];
            end
            TU_INSTALL: begin
                wr_en[0]       = 1'b1;
                wr_en[op_col]  = 1'b1;
                wr_tag[op_col] = rd_tag[0];
                wr_vld[op_col] = rd_vld[0];
                wr_tag[0]      = lk_tag;
                wr_vld[0]      = 1'b1;
            end
            default: ;
        endcase
    end

    // victim: lowest free non-major column, else the rotating pointer
    logic          free_found;
    logic [CW-1:0] free_col;
    logic [CW-1:0] rr_q [SETS];

    always_comb begin
        free_found = 1'b0;
        free_col   = '0;
        for (int c = WAYS - 1; c >= 1; c--) begin
            if (!rd_vld[c]) begin
                free_found = 1'b1;
                free_col   = CW'(c);
            end
        end
    end

    assign victim = free_found ? free_col : rr_q[lk_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= CW'(1);
            end
        end else if (op == TU_INSTALL && !free_found) begin
            rr_q[lk_set] <= CW'(rot_next(int'(rr_q[lk_set]), WAYS));
        end
    end

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    localparam int OFF_W = $clog2(WORDS),
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - SET_W,
    localparam int CW    = $clog2(WAYS),
    localparam int DA_W  = CW + SET_W + OFF_W,
    localparam int BLK_W = ADDR_W - OFF_W,
    localparam int CNT_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_confirm,
    output logic              rsp_cancel,
    output logic              mem_req_valid,
    output logic [BLK_W-1:0]  mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic [SET_W-1:0]  lk_set,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic [WAYS-1:0]   hit_vec,
    input  logic [CW-1:0]     victim,
    output tag_op_t           tag_op,
    output logic [CW-1:0]     tag_col,
    output logic [DA_W-1:0]   dm_raddr,
    input  logic [DATA_W-1:0] dm_rdata,
    output logic              dm_we,
    output logic [DA_W-1:0]   dm_waddr,
    output logic [DATA_W-1:0] dm_wdata
);

    localparam logic [CW-1:0] MAJOR = '0;

    pmc_state_t        state_q;
    logic [TAG_W-1:0]  tag_q;
    logic [SET_W-1:0]  set_q;
    logic [OFF_W-1:0]  off_q;
    logic [CW-1:0]     alt_q;
    logic              miss_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] buf_q [WORDS];

    logic              first_hit;
    logic              second_hit;
    logic [CW-1:0]     hit_col;
    logic              accept;
    logic [OFF_W-1:0]  cnt_lo;
    logic [OFF_W-1:0]  cnt_pm;
    logic              cnt_at_words;
    logic              cnt_at_last;

    assign first_hit    = hit_vec[0];
    assign second_hit   = |hit_vec[WAYS-1:1];
    assign cnt_lo       = cnt_q[OFF_W-1:0];
    assign cnt_pm       = OFF_W'(cnt_q - 1'b1);
    assign cnt_at_words = (cnt_q == CNT_W'(WORDS));
    assign cnt_at_last  = (cnt_q == CNT_W'(WORDS - 1));

    always_comb begin
        hit_col = '0;
        for (int c = 1; c < WAYS; c++) begin
            if (hit_vec[c]) begin
                hit_col = CW'(c);
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE) || (state_q == ST_LOOKUP && first_hit);
    assign accept    = req_valid && req_ready;
    assign lk_set    = set_q;
    assign lk_tag    = tag_q;

    assign mem_req_valid = (state_q == ST_FILL_REQ);
    assign mem_req_addr  = {tag_q, set_q};

    // data bank read address
    always_comb begin
        dm_raddr = {MAJOR, set_q, off_q};
        if (accept) begin
            dm_raddr = {MAJOR, req_addr[OFF_W +: SET_W], req_addr[OFF_W-1:0]};
        end else begin
            case (state_q)
                ST_LOOKUP: dm_raddr = {hit_col, set_q, off_q};
                ST_LOAD:   dm_raddr = {alt_q, set_q, cnt_lo};
                ST_COPY:   dm_raddr = {MAJOR, set_q, cnt_lo};
                default:   ;
            endcase
        end
    end

    // data bank write port
    always_comb begin
        dm_we    = 1'b0;
        dm_waddr = {MAJOR, set_q, cnt_lo};
        dm_wdata = mem_rsp_data;
        case (state_q)
            ST_COPY: begin
                dm_we    = (cnt_q != '0);
                dm_waddr = {alt_q, set_q, cnt_pm};
                dm_wdata = dm_rdata;
            end
            ST_STORE: begin
                dm_we    = 1'b1;
                dm_wdata = buf_q[cnt_lo];
            end
            ST_FILL: begin
                dm_we    = mem_rsp_valid;
            end
            default: ;
        endcase
    end

    // consumer-side response
    always_comb begin
        rsp_valid   = 1'b0;
        rsp_data    = dm_rdata;
        rsp_confirm = 1'b0;
        rsp_cancel  = 1'b0;
        case (state_q)
            ST_LOOKUP: begin
                rsp_valid   = 1'b1;
                rsp_confirm = first_hit;
                rsp_cancel  = !first_hit;
            end
            ST_RETRY: begin
                rsp_valid   = 1'b1;
                rsp_confirm = 1'b1;
            end
            ST_FILL: begin
                if (mem_rsp_valid && cnt_lo == off_q) begin
                    rsp_valid   = 1'b1;
                    rsp_confirm = 1'b1;
                    rsp_data    = mem_rsp_data;
                end
            end
            default: ;
        endcase
    end

    // tag operations at the end of a swap or a fill
    always_comb begin
        tag_op  = TU_NONE;
        tag_col = alt_q;
        if (state_q == ST_STORE && cnt_at_last) begin
            tag_op = TU_EXCHANGE;
        end else if (state_q == ST_FILL && mem_rsp_valid && cnt_at_last) begin
            tag_op = TU_INSTALL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            alt_q   <= '0;
            miss_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) state_q <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    cnt_q <= '0;
                    if (first_hit) begin
                        state_q <= accept ? ST_LOOKUP : ST_IDLE;
                    end else if (second_hit) begin
                        alt_q   <= hit_col;
                        miss_q  <= 1'b0;
                        state_q <= ST_RETRY;
                    end else begin
                        alt_q   <= victim;
                        miss_q  <= 1'b1;
                        state_q <= ST_COPY;
                    end
                end
                ST_RETRY: begin
                    cnt_q   <= '0;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (cnt_at_words) begin
                        cnt_q   <= '0;
                        state_q <= ST_COPY;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_COPY: begin
                    if (cnt_at_words) begin
                        cnt_q   <= '0;
                        state_q <= miss_q ? ST_FILL_REQ : ST_STORE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STORE: begin
                    if (cnt_at_last) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FILL_REQ: begin
                    cnt_q <= '0;
                    if (mem_req_ready) state_q <= ST_FILL;
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        if (cnt_at_last) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // request capture and swap buffer
    always_ff @(posedge clk) begin
        if (accept) begin
            tag_q <= req_addr[ADDR_W-1 -: TAG_W];
            set_q <= req_addr[OFF_W +: SET_W];
            off_q <= req_addr[OFF_W-1:0];
        end
        if (state_q == ST_LOAD && cnt_q != '0) begin
            buf_q[cnt_pm] <= dm_rdata;
        end
    end

endmodule

// File: rtl/pmc_cache.sv
module pmc_cache
    import pmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    localparam int OFF_W = $clog2(WORDS),
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - SET_W,
    localparam int CW    = $clog2(WAYS),
    localparam int DA_W  = CW + SET_W + OFF_W,
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_confirm,
    output logic              rsp_cancel,
    output logic              mem_req_valid,
    output logic [BLK_W-1:0]  mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic [WAYS-1:0]   hit_vec;
    logic [CW-1:0]     victim;
    tag_op_t           tag_op;
    logic [CW-1:0]     tag_col;
    logic [DA_W-1:0]   dm_raddr;
    logic [DATA_W-1:0] dm_rdata;
    logic              dm_we;
    logic [DA_W-1:0]   dm_waddr;
    logic [DATA_W-1:0] dm_wdata;

    pmc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_confirm(rsp_confirm), .rsp_cancel(rsp_cancel),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .lk_set(lk_set), .lk_tag(lk_tag), .hit_vec(hit_vec), .victim(victim),
        .tag_op(tag_op), .tag_col(tag_col),
        .dm_raddr(dm_raddr), .dm_rdata(dm_rdata),
        .dm_we(dm_we), .dm_waddr(dm_waddr), .dm_wdata(dm_wdata)
    );

    pmc_tag_banks #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst(rst),
        .lk_set(lk_set), .lk_tag(lk_tag),
        .hit_vec(hit_vec), .victim(victim),
        .op(tag_op), .op_col(tag_col)
    );

    pmc_data_bank #(
        .DEPTH(WAYS * SETS * WORDS), .DATA_W(DATA_W)
    ) u_data (
        .clk(clk),
        .rd_addr(dm_raddr), .rd_data(dm_rdata),
        .wr_en(dm_we), .wr_addr(dm_waddr), .wr_data(dm_wdata)
    );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int BLK_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_confirm,
    input logic             rsp_cancel,
    input logic             mem_req_valid,
    input logic [BLK_W-1:0] mem_req_addr,
    input logic             mem_req_ready
);

    AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (rsp_confirm || rsp_cancel) |-> (rsp_valid && !(rsp_confirm && rsp_cancel))); // R4

    AST_ACCEPT_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_valid && (rsp_confirm || rsp_cancel))); // R2

    AST_CANCEL_STALLS: assert property (@(posedge clk) disable iff (rst)
        rsp_cancel |=> !req_ready); // R9

    AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready); // R9

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R6

    AST_SINGLE_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        (rsp_confirm && !(req_valid && req_ready)) |=> !rsp_valid); // R9

endmodule

bind pmc_cache pmc_checker #(.BLK_W(BLK_W)) u_pmc_checker (.*);

// File: tb/test_pmc_cache.sv
module test_pmc_cache;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int WAYS   = 4;
    localparam int SETS   = 8;
    localparam int WORDS  = 4;
    localparam int OFF_W  = 2;
    localparam int SET_W  = 3;
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int BLK_W  = ADDR_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_confirm;
    logic              rsp_cancel;
    logic              mem_req_valid;
    logic [BLK_W-1:0]  mem_req_addr;
    logic              mem_req_ready = 1'b0;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    pmc_cache #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)
    ) i_pmc_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_confirm(rsp_confirm), .rsp_cancel(rsp_cancel),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural model of the column contents
    logic [TAG_W-1:0] m_tag [WAYS][SETS];
    bit               m_vld [WAYS][SETS];
    int               m_rr  [SETS];

    function automatic logic [DATA_W-1:0] pat(input logic [BLK_W-1:0] b, input int w);
        return {8'h5A, 2'b00, b, 6'b000000, 2'(w)};
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
        return {TAG_W'(t), SET_W'(s), OFF_W'(o)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R9", "no response while idle", 32'(rsp_valid), 0);
        end
    endtask

    // issue one request at a negedge where req_ready is expected high;
    // returns at a negedge where req_ready is expected high again
    task automatic run_req(input logic [ADDR_W-1:0] a, input int gap, output int kind);
        logic [TAG_W-1:0] t;
        int s;
        int o;
        int hc;
        int v;
        t  = a[ADDR_W-1 -: TAG_W];
        s  = int'(a[OFF_W +: SET_W]);
        o  = int'(a[OFF_W-1:0]);
        hc = -1;
        for (int c = 0; c < WAYS; c++) begin
            if (m_vld[c][s] && m_tag[c][s] == t) hc = c;
        end
        check(req_ready == 1'b1, "R9", "ready before issue", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R2", "dispatch one cycle after accept", 32'(rsp_valid), 1);
        if (m_vld[0][s]) begin
            check(rsp_data == pat({m_tag[0][s], SET_W'(s)}, o), "R2", "major-location word",
                  rsp_data, pat({m_tag[0][s], SET_W'(s)}, o));
        end
        if (hc == 0) begin
            kind = 1;
            check(rsp_confirm && !rsp_cancel, "R3", "first hit confirmed",
                  {rsp_confirm, rsp_cancel}, 2'b10);
            check(req_ready == 1'b1, "R3", "ready in hit cycle", 32'(req_ready), 1);
            check(rsp_data == pat({t, SET_W'(s)}, o), "R3", "first hit word",
                  rsp_data, pat({t, SET_W'(s)}, o));
        end else begin
            check(rsp_cancel && !rsp_confirm, "R4", "speculative word cancelled",
                  {rsp_confirm, rsp_cancel}, 2'b01);
            if (hc > 0) begin
                kind = 2;
                @(negedge clk);
                check(rsp_valid && rsp_confirm && !rsp_cancel, "R5", "second hit confirm",
                      {rsp_valid, rsp_confirm, rsp_cancel}, 3'b110);
                check(rsp_data == pat({t, SET_W'(s)}, o), "R5", "second hit word",
                      rsp_data, pat({t, SET_W'(s)}, o));
                for (int i = 0; i < 200; i++) begin
                    @(negedge clk);
                    check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R9", "quiet swap",
                          {rsp_valid, mem_req_valid}, 0);
                    if (req_ready) break;
                end
                m_tag[hc][s] = m_tag[0][s];
                m_tag[0][s]  = t;
            end else begin
                kind = 0;
                for (int i = 0; i < 200; i++) begin
                    @(negedge clk);
                    if (mem_req_valid) break;
                    check(!req_ready && !rsp_valid, "R9", "stall before fetch",
                          {req_ready, rsp_valid}, 0);
                end
                check(mem_req_valid == 1'b1, "R6", "fetch raised", 32'(mem_req_valid), 1);
                check(mem_req_addr == {t, SET_W'(s)}, "R6", "fetch address",
                      32'(mem_req_addr), 32'({t, SET_W'(s)}));
                check(req_ready == 1'b0, "R9", "stall during fetch", 32'(req_ready), 0);
                @(negedge clk);
                check(mem_req_valid && mem_req_addr == {t, SET_W'(s)}, "R6", "fetch held",
                      32'(mem_req_addr), 32'({t, SET_W'(s)}));
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int w = 0; w < WORDS; w++) begin
                    for (int g = 0; g < gap; g++) begin
                        mem_rsp_valid = 1'b0;
                        #1;
                        check(rsp_valid == 1'b0, "R6", "no forward in gap", 32'(rsp_valid), 0);
                        @(negedge clk);
                    end
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pat({t, SET_W'(s)}, w);
                    #1;
                    check(rsp_valid == (w == o), "R6", "forward only requested word",
                          32'(rsp_valid), 32'(w == o));
                    if (w == o) begin
                        check(rsp_confirm && !rsp_cancel && rsp_data == pat({t, SET_W'(s)}, o),
                              "R6", "forwarded word", rsp_data, pat({t, SET_W'(s)}, o));
                    end
                    @(negedge clk);
                end
                mem_rsp_valid = 1'b0;
                v = 0;
                for (int c = WAYS - 1; c >= 1; c--) begin
                    if (!m_vld[c][s]) v = c;
                end
                if (v == 0) begin
                    v = m_rr[s];
                    m_rr[s] = (m_rr[s] >= WAYS - 1) ? 1 : m_rr[s] + 1;
                end
                m_tag[v][s] = m_tag[0][s];
                m_vld[v][s] = m_vld[0][s];
                m_tag[0][s] = t;
                m_vld[0][s] = 1'b1;
            end
        end
    endtask

    task automatic expect_kind(input logic [ADDR_W-1:0] a, input int exp, input string req);
        int k;
        run_req(a, 0, k);
        check(k == exp, req, "outcome kind (0 miss, 1 first, 2 second)", 32'(k), 32'(exp));
    endtask

    initial begin
        int k;
        logic [15:0] lfsr;
        for (int s = 0; s < SETS; s++) begin
            m_rr[s] = 1;
            for (int c = 0; c < WAYS; c++) begin
                m_vld[c][s] = 1'b0;
                m_tag[c][s] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1", "quiet after reset",
              {rsp_valid, mem_req_valid}, 0);

        run_req(mk(5, 1, 2), 1, k);
        check(k == 0, "R1", "first reference misses", 32'(k), 0);
        expect_kind(mk(5, 1, 0), 1, "R3");
        expect_kind(mk(5, 1, 3), 1, "R3");   // issued in the previous hit's dispatch cycle
        idle(2);
        expect_kind(mk(6, 1, 1), 0, "R1");
        expect_kind(mk(5, 1, 2), 2, "R5");
        expect_kind(mk(5, 1, 1), 1, "R7");
        expect_kind(mk(6, 1, 0), 2, "R7");
        expect_kind(mk(7, 1, 0), 0, "R8");
        expect_kind(mk(8, 1, 0), 0, "R8");
        expect_kind(mk(9, 1, 3), 0, "R8");   // set full: pointer picks column 1
        expect_kind(mk(5, 1, 0), 0, "R8");   // displaced by the pointer
        expect_kind(mk(8, 1, 1), 2, "R8");
        expect_kind(mk(6, 1, 0), 0, "R8");
        expect_kind(mk(5, 2, 0), 0, "R1");   // other set untouched

        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_req(mk(int'(lfsr[2:0]) % 6, int'(lfsr[3]), int'(lfsr[5:4])),
                    int'(lfsr[6]), k);
            if (lfsr[8:7] == 2'b00) idle(1);
        end
        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule